// File: doc/BRIEF.md
# FIFO-Threshold DMA Burst Requester

This block sits beside the transmit and receive FIFOs of an SPI controller and decides when a memory-side mover should transfer a fixed-size group of 64-bit words. It compares the fill level of each FIFO with a programmed threshold. When the transmit FIFO runs low, it asks for a fill burst. When the receive FIFO has collected enough words, it asks for a drain burst.

Each direction has its own burst counter and its own counter enable. A direction may have only one burst outstanding at a time, using a level request that the mover acknowledges with a one-cycle pulse. Every acknowledged burst lowers that direction's counter by one. When both directions have finished, the block clears its own enable and raises a one-cycle completion pulse.

Software programs the block through a small register port. The port holds a control word and the two counters, and the counters can be read back while bursts are running.

Top module: `fifo_dma_burst_req`

## Requirements
- R1: After reset, `rd_req`, `wr_req`, `done` and `urgent` are 0, and the control word and both counters read as 0.
- R2: While enabled, with the fill-side counter enable set and the fill counter nonzero, `rd_req` rises one clock after `tx_level` is strictly less than the TX threshold. A level equal to the threshold raises nothing. `rd_len` carries the fill burst field.
- R3: Under the same conditions on the drain side, `wr_req` rises one clock after `rx_level` is strictly greater than the RX threshold. A level equal to the threshold raises nothing. `wr_len` carries the drain burst field.
- R4: A raised request stays high until its acknowledge is seen, so only one burst is outstanding per direction. In the cycle after the acknowledge the request is low.
- R5: Each acknowledged burst lowers that direction's counter by exactly one. Register address 1 reads the fill counter and address 2 reads the drain counter.
- R6: A burst field holds the length minus one. Only the values 1 to 7 (lengths 2 to 8) can raise a request. The values 0 and 8 to 15 raise nothing and leave the counter unchanged.
- R7: A direction whose counter enable is 0 never raises a request, and it counts as finished for completion.
- R8: When the block is enabled and both directions are finished (counter enable 0 or counter 0), the enable clears and `done` pulses high for one cycle. The control word then reads with bit 0 equal to 0.
- R9: An acknowledge with no outstanding request in that direction has no effect on the counter.
- R10: `urgent` follows control bit 1.
- R11: The control word at address 0 is laid out as follows: bit 0 enable, bit 1 urgent, bit 2 fill counter enable, bit 3 drain counter enable, [8:4] TX threshold, [13:9] RX threshold, [17:14] fill burst field, [21:18] drain burst field. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on `cfg_addr`) |
| tx_level | input | 5 | Words currently held in the transmit FIFO (0 to 16) |
| rx_level | input | 5 | Words currently held in the receive FIFO (0 to 16) |
| rd_req | output | 1 | Fill burst request toward the mover |
| rd_len | output | 4 | Fill burst length minus one |
| rd_ack | input | 1 | One-cycle pulse: fill burst complete |
| wr_req | output | 1 | Drain burst request toward the mover |
| wr_len | output | 4 | Drain burst length minus one |
| wr_ack | input | 1 | One-cycle pulse: drain burst complete |
| urgent | output | 1 | Priority hint to the mover |
| done | output | 1 | One-cycle pulse when all bursts are finished |

## Verification
The assertions assume the following about the inputs:
- An acknowledge is a single-cycle pulse that the mover normally raises only while the matching request is high.
- The FIFO levels never exceed the FIFO depth.
- A counter is reloaded only through the register port.

The stimulus drives every input half a clock away from the sampling edge. It drops each acknowledge after one cycle. It sends one stray acknowledge on purpose, to exercise R9. It keeps the levels between 0 and 16, and it moves a level away from its threshold whenever a second request is not wanted.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;
   localparam int REG_ADDR_W = 2;

   typedef enum logic [REG_ADDR_W-1:0] {
      REG_CTRL   = 2'd0,
      REG_RD_CNT = 2'd1,
      REG_WR_CNT = 2'd2,
      REG_SPARE  = 2'd3
   } reg_addr_e;

   // single-bit flags of the control word; multi-bit fields start at FLD_BASE
   localparam int BIT_EN    = 0;
   localparam int BIT_URG   = 1;
   localparam int BIT_RD_CE = 2;
   localparam int BIT_WR_CE = 3;
   localparam int FLD_BASE  = 4;

   typedef enum logic {
      DIR_FILL  = 1'b0,
      DIR_DRAIN = 1'b1
   } dir_e;
endpackage

// File: rtl/dma_burst_chan.sv
module dma_burst_chan
   import dma_burst_pkg::*;
#(
   parameter dir_e DIR       = DIR_FILL,
   parameter int   LVL_W     = 5,
   parameter int   THR_W     = 5,
   parameter int   BLEN_W    = 4,
   parameter int   CNT_W     = 16,
   parameter int   MIN_BURST = 2,
   parameter int   MAX_BURST = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              cnt_en,
   input  logic [THR_W-1:0]  thr,
   input  logic [BLEN_W-1:0] blen_m1,
   input  logic [LVL_W-1:0]  level,
   input  logic              load,
   input  logic [CNT_W-1:0]  load_val,
   input  logic              ack,
   output logic              req,
   output logic [CNT_W-1:0]  count,
   output logic              fin
);
   localparam int CMP_W = (LVL_W > THR_W) ? LVL_W : THR_W;

   logic [CMP_W-1:0] lvl_x;
   logic [CMP_W-1:0] thr_x;
   logic             trig;
   logic             len_ok;
   logic             arm;

   assign lvl_x = CMP_W'(level);
   assign thr_x = CMP_W'(thr);

   generate
      if (DIR == DIR_FILL) begin : g_fill
         assign trig = (lvl_x < thr_x);
      end else begin : g_drain
         assign trig = (lvl_x > thr_x);
      end
   endgenerate

   assign len_ok = (blen_m1 >= BLEN_W'(MIN_BURST - 1)) &&
                   (blen_m1 <= BLEN_W'(MAX_BURST - 1));
   assign arm    = en && cnt_en && (count != '0) && len_ok && trig && !req;
   assign fin    = !cnt_en || (count == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req   <= 1'b0;
         count <= '0;
      end else begin
         if (req && ack) begin
            req <= 1'b0;
         end else if (arm) begin
            req <= 1'b1;
         end
         if (load) begin
            count <= load_val;
         end else if (req && ack) begin
            count <= count - CNT_W'(1);
         end
      end
   end

   p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !ack) |=> req)
      else $error("request dropped without acknowledge");

   p_req_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (req && ack) |=> !req)
      else $error("request not released after acknowledge");

   p_count_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req && ack && !load) |=> (count == $past(count) - CNT_W'(1)))
      else $error("counter did not step down by one");

   p_len_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req) |-> $past(len_ok))
      else $error("request raised with an invalid burst length");

   p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !req) |=> !req)
      else $error("request raised by a disabled direction");

   p_stray_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!req && !load) |=> (count == $past(count)))
      else $error("counter moved with no outstanding burst");
endmodule

// File: rtl/dma_burst_regs.sv
module dma_burst_regs
   import dma_burst_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int THR_W  = 5,
   parameter int BLEN_W = 4,
   parameter int CNT_W  = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [REG_ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0]     cfg_wdata,
   output logic [DATA_W-1:0]     cfg_rdata,
   input  logic [CNT_W-1:0]      rd_count,
   input  logic [CNT_W-1:0]      wr_count,
   input  logic                  rd_fin,
   input  logic                  wr_fin,
   output logic                  en,
   output logic                  urgent,
   output logic                  rd_ce,
   output logic                  wr_ce,
   output logic [THR_W-1:0]      tx_thr,
   output logic [THR_W-1:0]      rx_thr,
   output logic [BLEN_W-1:0]     rd_blen,
   output logic [BLEN_W-1:0]     wr_blen,
   output logic                  ld_rd,
   output logic                  ld_wr,
   output logic [CNT_W-1:0]      ld_val,
   output logic                  done
);
   localparam int POS_TX = FLD_BASE;
   localparam int POS_RX = POS_TX + THR_W;
   localparam int POS_RB = POS_RX + THR_W;
   localparam int POS_WB = POS_RB + BLEN_W;

   logic ctrl_wr;

   assign ctrl_wr = cfg_we && (reg_addr_e'(cfg_addr) == REG_CTRL);
   assign ld_rd   = cfg_we && (reg_addr_e'(cfg_addr) == REG_RD_CNT);
   assign ld_wr   = cfg_we && (reg_addr_e'(cfg_addr) == REG_WR_CNT);
   assign ld_val  = cfg_wdata[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en      <= 1'b0;
         urgent  <= 1'b0;
         rd_ce   <= 1'b0;
         wr_ce   <= 1'b0;
         tx_thr  <= '0;
         rx_thr  <= '0;
         rd_blen <= '0;
         wr_blen <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (ctrl_wr) begin
            en      <= cfg_wdata[BIT_EN];
            urgent  <= cfg_wdata[BIT_URG];
            rd_ce   <= cfg_wdata[BIT_RD_CE];
            wr_ce   <= cfg_wdata[BIT_WR_CE];
            tx_thr  <= cfg_wdata[POS_TX +: THR_W];
            rx_thr  <= cfg_wdata[POS_RX +: THR_W];
            rd_blen <= cfg_wdata[POS_RB +: BLEN_W];
            wr_blen <= cfg_wdata[POS_WB +: BLEN_W];
         end else if (en && rd_fin && wr_fin) begin
            en   <= 1'b0;
            done <= 1'b1;
         end
      end
   end

   always_comb begin
      cfg_rdata = '0;
      case (reg_addr_e'(cfg_addr))
         REG_CTRL: begin
            cfg_rdata[BIT_EN]               = en;
            cfg_rdata[BIT_URG]              = urgent;
            cfg_rdata[BIT_RD_CE]            = rd_ce;
            cfg_rdata[BIT_WR_CE]            = wr_ce;
            cfg_rdata[POS_TX +: THR_W]      = tx_thr;
            cfg_rdata[POS_RX +: THR_W]      = rx_thr;
            cfg_rdata[POS_RB +: BLEN_W]     = rd_blen;
            cfg_rdata[POS_WB +: BLEN_W]     = wr_blen;
         end
         REG_RD_CNT: cfg_rdata = DATA_W'(rd_count);
         REG_WR_CNT: cfg_rdata = DATA_W'(wr_count);
         default:    cfg_rdata = '0;
      endcase
   end

   p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !en)
      else $error("enable still set while done pulses");

   p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done held for more than one cycle");

   p_self_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en) |-> (done || $past(ctrl_wr)))
      else $error("enable cleared without completion or write");
endmodule

// File: rtl/fifo_dma_burst_req.sv
module fifo_dma_burst_req
   import dma_burst_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int FIFO_DEPTH = 16,
   parameter int THR_W      = 5,
   parameter int BLEN_W     = 4,
   parameter int CNT_W      = 16,
   parameter int MIN_BURST  = 2,
   parameter int MAX_BURST  = 8,
   localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [REG_ADDR_W-1:0] cfg_addr,
   input  logic [DATA_W-1:0]     cfg_wdata,
   output logic [DATA_W-1:0]     cfg_rdata,
   input  logic [LVL_W-1:0]      tx_level,
   input  logic [LVL_W-1:0]      rx_level,
   output logic                  rd_req,
   output logic [BLEN_W-1:0]     rd_len,
   input  logic                  rd_ack,
   output logic                  wr_req,
   output logic [BLEN_W-1:0]     wr_len,
   input  logic                  wr_ack,
   output logic                  urgent,
   output logic                  done
);
   localparam int CTRL_BITS = FLD_BASE + 2 * THR_W + 2 * BLEN_W;

   generate
      if (MIN_BURST < 2) begin : g_bad_min
         $error("MIN_BURST must be at least 2");
      end
      if (MAX_BURST < MIN_BURST || MAX_BURST > FIFO_DEPTH) begin : g_bad_max
         $error("MAX_BURST must lie between MIN_BURST and FIFO_DEPTH");
      end
      if (MAX_BURST > (1 << BLEN_W)) begin : g_bad_blen
         $error("BLEN_W too narrow for MAX_BURST");
      end
      if ((1 << THR_W) <= FIFO_DEPTH) begin : g_bad_thr
         $error("THR_W too narrow for FIFO_DEPTH");
      end
      if (CNT_W > DATA_W || CTRL_BITS > DATA_W) begin : g_bad_data
         $error("DATA_W too narrow for the register fields");
      end
   endgenerate

   logic              en;
   logic              rd_ce;
   logic              wr_ce;
   logic [THR_W-1:0]  tx_thr;
   logic [THR_W-1:0]  rx_thr;
   logic [BLEN_W-1:0] rd_blen;
   logic [BLEN_W-1:0] wr_blen;
   logic              ld_rd;
   logic              ld_wr;
   logic [CNT_W-1:0]  ld_val;
   logic [CNT_W-1:0]  rd_count;
   logic [CNT_W-1:0]  wr_count;
   logic              rd_fin;
   logic              wr_fin;

   dma_burst_regs #(
      .DATA_W (DATA_W),
      .THR_W  (THR_W),
      .BLEN_W (BLEN_W),
      .CNT_W  (CNT_W)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .rd_count  (rd_count),
      .wr_count  (wr_count),
      .rd_fin    (rd_fin),
      .wr_fin    (wr_fin),
      .en        (en),
      .urgent    (urgent),
      .rd_ce     (rd_ce),
      .wr_ce     (wr_ce),
      .tx_thr    (tx_thr),
      .rx_thr    (rx_thr),
      .rd_blen   (rd_blen),
      .wr_blen   (wr_blen),
      .ld_rd     (ld_rd),
      .ld_wr     (ld_wr),
      .ld_val    (ld_val),
      .done      (done)
   );

   dma_burst_chan #(
      .DIR       (DIR_FILL),
      .LVL_W     (LVL_W),
      .THR_W     (THR_W),
      .BLEN_W    (BLEN_W),
      .CNT_W     (CNT_W),
      .MIN_BURST (MIN_BURST),
      .MAX_BURST (MAX_BURST)
   ) fill_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .cnt_en   (rd_ce),
      .thr      (tx_thr),
      .blen_m1  (rd_blen),
      .level    (tx_level),
      .load     (ld_rd),
      .load_val (ld_val),
      .ack      (rd_ack),
      .req      (rd_req),
      .count    (rd_count),
      .fin      (rd_fin)
   );

   dma_burst_chan #(
      .DIR       (DIR_DRAIN),
      .LVL_W     (LVL_W),
      .THR_W     (THR_W),
      .BLEN_W    (BLEN_W),
      .CNT_W     (CNT_W),
      .MIN_BURST (MIN_BURST),
      .MAX_BURST (MAX_BURST)
   ) drain_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (en),
      .cnt_en   (wr_ce),
      .thr      (rx_thr),
      .blen_m1  (wr_blen),
      .level    (rx_level),
      .load     (ld_wr),
      .load_val (ld_val),
      .ack      (wr_ack),
      .req      (wr_req),
      .count    (wr_count),
      .fin      (wr_fin)
   );

   assign rd_len = rd_blen;
   assign wr_len = wr_blen;

   p_done_needs_fin_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(en && rd_fin && wr_fin))
      else $error("done raised before both directions finished");
endmodule

// File: tb/fifo_dma_burst_req_tb_top.sv
module fifo_dma_burst_req_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = 2'd0;
   logic [31:0] cfg_wdata = 32'd0;
   logic [31:0] cfg_rdata;
   logic [4:0]  tx_level = 5'd16;
   logic [4:0]  rx_level = 5'd0;
   logic        rd_req;
   logic [3:0]  rd_len;
   logic        rd_ack = 1'b0;
   logic        wr_req;
   logic [3:0]  wr_len;
   logic        wr_ack = 1'b0;
   logic        urgent;
   logic        done;

   int n_tests = 0;
   int n_fail  = 0;
   int rd_q[$];
   int wr_q[$];
   int done_q[$];
   logic prev_rd = 1'b0;
   logic prev_wr = 1'b0;
   logic prev_done = 1'b0;
   logic [31:0] rv;

   always #5 clk = ~clk;

   fifo_dma_burst_req dut_i (
      .clk (clk), .rst_n (rst_n),
      .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
      .tx_level (tx_level), .rx_level (rx_level),
      .rd_req (rd_req), .rd_len (rd_len), .rd_ack (rd_ack),
      .wr_req (wr_req), .wr_len (wr_len), .wr_ack (wr_ack),
      .urgent (urgent), .done (done)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] ctrl(input bit e, input bit u, input bit rce, input bit wce,
                                        input int tx, input int rx, input int rb, input int wb);
      return 32'(e) | (32'(u) << 1) | (32'(rce) << 2) | (32'(wce) << 3) |
             (32'(tx) << 4) | (32'(rx) << 9) | (32'(rb) << 14) | (32'(wb) << 18);
   endfunction

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic pulse_rd_ack();
      @(negedge clk); rd_ack = 1'b1;
      @(negedge clk); rd_ack = 1'b0;
   endtask

   task automatic pulse_wr_ack();
      @(negedge clk); wr_ack = 1'b1;
      @(negedge clk); wr_ack = 1'b0;
   endtask

   // monitor: every request or done edge must match a queued expectation
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         if (rd_req && !prev_rd) begin
            if (rd_q.size() == 0) check("R2 unexpected rd_req", 32'd1, 32'd0);
            else check("R2 rd_len", 32'(rd_len), 32'(rd_q.pop_front()));
         end
         if (wr_req && !prev_wr) begin
            if (wr_q.size() == 0) check("R3 unexpected wr_req", 32'd1, 32'd0);
            else check("R3 wr_len", 32'(wr_len), 32'(wr_q.pop_front()));
         end
         if (done && !prev_done) begin
            if (done_q.size() == 0) check("R8 unexpected done", 32'd1, 32'd0);
            else check("R8 done pulse", 32'd1, 32'(done_q.pop_front()));
         end
         if (done && prev_done) check("R8 done longer than one cycle", 32'd1, 32'd0);
      end
      prev_rd = rd_req; prev_wr = wr_req; prev_done = done;
   end

   initial begin
      repeat (20000) @(posedge clk);
      check("watchdog expired", 32'd1, 32'd0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset state
      check("R1 rd_req", 32'(rd_req), 0);
      check("R1 wr_req", 32'(wr_req), 0);
      check("R1 done", 32'(done), 0);
      check("R1 urgent", 32'(urgent), 0);
      reg_rd(2'd0, rv); check("R1 ctrl", rv, 0);
      reg_rd(2'd1, rv); check("R1 rd count", rv, 0);

      // R11 / R10 register layout and urgent
      reg_wr(2'd1, 32'd3);
      reg_wr(2'd2, 32'd2);
      reg_rd(2'd1, rv); check("R11 rd count", rv, 3);
      reg_rd(2'd2, rv); check("R11 wr count", rv, 2);
      reg_wr(2'd0, ctrl(0, 1, 0, 0, 0, 0, 0, 0));
      check("R10 urgent high", 32'(urgent), 1);
      reg_wr(2'd0, ctrl(1, 1, 1, 1, 8, 7, 7, 3));
      reg_rd(2'd0, rv); check("R11 ctrl readback", rv, ctrl(1, 1, 1, 1, 8, 7, 7, 3));
      reg_rd(2'd3, rv); check("R11 spare reads zero", rv, 0);
      step(3);

      // R2 fill threshold, strict compare
      tx_level = 5'd8;
      step(3);
      check("R2 equal level no request", 32'(rd_req), 0);
      rd_q.push_back(7);
      tx_level = 5'd7;
      step(2);
      check("R2 rd_req raised", 32'(rd_req), 1);
      step(3);
      check("R4 rd_req held", 32'(rd_req), 1);
      pulse_rd_ack();
      tx_level = 5'd16;
      check("R4 rd_req low after ack", 32'(rd_req), 0);
      reg_rd(2'd1, rv); check("R5 rd count after one burst", rv, 2);

      // R9 stray acknowledge
      pulse_rd_ack();
      step(1);
      reg_rd(2'd1, rv); check("R9 stray ack ignored", rv, 2);

      // R3 drain threshold, strict compare
      rx_level = 5'd7;
      step(3);
      check("R3 equal level no request", 32'(wr_req), 0);
      wr_q.push_back(3);
      rx_level = 5'd8;
      step(2);
      check("R3 wr_req raised", 32'(wr_req), 1);
      pulse_wr_ack();
      rx_level = 5'd0;
      reg_rd(2'd2, rv); check("R5 wr count after one burst", rv, 1);

      // R6 invalid burst fields raise nothing
      reg_wr(2'd0, ctrl(1, 1, 1, 1, 8, 7, 0, 3));
      tx_level = 5'd0;
      step(4);
      check("R6 length-one field no request", 32'(rd_req), 0);
      reg_wr(2'd0, ctrl(1, 1, 1, 1, 8, 7, 8, 3));
      step(4);
      check("R6 oversize field no request", 32'(rd_req), 0);
      reg_rd(2'd1, rv); check("R6 rd count unchanged", rv, 2);
      rd_q.push_back(1);
      rd_q.push_back(1);
      reg_wr(2'd0, ctrl(1, 1, 1, 1, 8, 7, 1, 3));
      step(1);
      check("R6 min length requests", 32'(rd_req), 1);
      pulse_rd_ack();
      check("R4 gap after ack", 32'(rd_req), 0);
      step(1);
      check("R4 next burst raised", 32'(rd_req), 1);
      pulse_rd_ack();
      tx_level = 5'd16;
      step(2);
      reg_rd(2'd1, rv); check("R5 rd count reaches zero", rv, 0);

      // R8 completion after last drain burst
      wr_q.push_back(3);
      done_q.push_back(1);
      rx_level = 5'd8;
      step(2);
      check("R3 last wr_req", 32'(wr_req), 1);
      pulse_wr_ack();
      rx_level = 5'd0;
      step(3);
      check("R8 done low again", 32'(done), 0);
      reg_rd(2'd0, rv); check("R8 enable self-cleared", rv, ctrl(0, 1, 1, 1, 8, 7, 1, 3));

      // R7 disabled drain direction
      reg_wr(2'd1, 32'd1);
      reg_wr(2'd2, 32'd5);
      rx_level = 5'd16;
      rd_q.push_back(3);
      done_q.push_back(1);
      reg_wr(2'd0, ctrl(1, 1, 1, 0, 8, 0, 3, 3));
      tx_level = 5'd0;
      step(2);
      check("R7 rd_req with drain off", 32'(rd_req), 1);
      check("R7 wr_req stays low", 32'(wr_req), 0);
      pulse_rd_ack();
      tx_level = 5'd16;
      step(3);
      reg_rd(2'd2, rv); check("R7 wr count untouched", rv, 5);
      reg_rd(2'd0, rv); check("R7 enable cleared", rv & 32'd1, 0);

      // R7/R8 both directions off: finishes at once
      done_q.push_back(1);
      reg_wr(2'd0, ctrl(1, 0, 0, 0, 8, 0, 3, 3));
      step(3);
      check("R10 urgent low", 32'(urgent), 0);
      reg_rd(2'd0, rv); check("R8 immediate finish", rv, ctrl(0, 0, 0, 0, 8, 0, 3, 3));
      rx_level = 5'd0;

      check("R2 rd expectations consumed", 32'(rd_q.size()), 0);
      check("R3 wr expectations consumed", 32'(wr_q.size()), 0);
      check("R8 done expectations consumed", 32'(done_q.size()), 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule